// File: doc/BRIEF.md
# Descriptor Submission Ring Producer

This block is the producing end of a circular queue of DMA copy descriptors. A requester presents one copy request per cycle. The request carries a 64-bit source address, a 64-bit destination address, a source and a destination function ID, a byte count, and two flags: one asks for a completion interrupt, the other asks for a fence. The block accepts the request only when two conditions hold. The ring must have a free slot, and the byte count must be within the allowed maximum. An accepted request is formatted into a fixed 256-bit descriptor that carries a 16-bit command tag. The descriptor is stored in the slot named by the head index. The original byte count is kept in a per-slot side table so that residue can be computed later.

After a write, the head index moves forward modulo the ring depth. One cycle after that, a doorbell strobe publishes the new head to the fetch engine. The consumer side returns its tail index on an input port. One slot is always kept empty, so that a full ring can be told apart from an empty one. Both stored tables can be read through a combinational read port indexed by slot. A flush input returns the head index and the command tag to zero.

Top module: `sq_producer`

## Requirements
- R1: After reset the block shows no response and no doorbell. The first accepted request receives command tag 0 and is written to slot 0, and its doorbell reports head 1.
- R2: A request is refused with the full flag set when (head+1) mod DEPTH equals the consumer tail. A refused request leaves the head, the command tag, the ring contents and the doorbell unchanged.
- R3: A byte count greater than 0x100000 is refused with the too-long flag set. A count of exactly 0x100000 is accepted. If a request is both too long and meets a full ring, it raises both flags.
- R4: The descriptor layout is fixed. Bits [7:0] hold the opcode, which is always 0 (copy); the other defined opcodes are 1 (read immediate), 2 (write immediate), 6 (remote-host interrupt) and 7 (no-op). Bits [15:8] hold the control flags, [31:16] the TLP settings (always 0), [47:32] are reserved (0), [63:48] hold the command tag and [95:64] the byte count. Bits [127:96] and [159:128] hold the low and high source words, and bits [191:160] and [223:192] the low and high destination words. Bits [239:224] hold the destination function ID and [255:240] the source function ID.
- R5: Control bit 5 (descriptor bit 13) is set only when neither function ID equals 0xFFFF.
- R6: Control bit 6 (descriptor bit 14) follows the interrupt flag, and control bit 7 (descriptor bit 15) follows the fence flag.
- R7: The command tag goes up by one for each accepted request and wraps modulo 65536, independently of the ring index. Each accepted response reports the tag that was used.
- R8: An accepted request moves the head forward by one modulo DEPTH. A response appears one cycle after the request, and a doorbell carrying the new head follows one cycle after the response.
- R9: The original byte count of each accepted request can be read from the side table at its slot.
- R10: Flush takes priority over a request in the same cycle, which then gets no response. Flush returns both the head and the command tag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Return head and command tag to zero |
| req_valid | input | 1 | Copy request present this cycle |
| req_src | input | 64 | Source address |
| req_dst | input | 64 | Destination address |
| req_sfid | input | 16 | Source function ID, 0xFFFF = none |
| req_dfid | input | 16 | Destination function ID, 0xFFFF = none |
| req_len | input | 32 | Byte count |
| req_irq | input | 1 | Interrupt on completion wanted |
| req_fence | input | 1 | Fence wanted |
| cons_tail | input | IDX_W | Consumer tail index |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_ok | output | 1 | Request accepted |
| resp_full | output | 1 | Refused, ring full |
| resp_toolong | output | 1 | Refused, byte count too large |
| resp_cid | output | 16 | Command tag given to the accepted request |
| db_valid | output | 1 | Doorbell strobe |
| db_head | output | IDX_W | Published head index |
| rd_idx | input | IDX_W | Read slot |
| rd_desc | output | 256 | Descriptor stored in the read slot |
| rd_len | output | 32 | Original byte count stored in the read slot |

## Verification
The bench fills the ring against a fixed tail until the full condition appears. A design that did not keep one slot empty would accept a sixteenth request and overwrite a live entry. The bench sends counts of exactly 0x100000 and 0x100001; a comparison with the wrong bound would turn away a legal maximum or pass an oversized copy. It drives every combination of absent and valid function IDs, because a design that gated bit 5 on either ID alone would set it when only one side is valid. More than 65536 requests are run while the tail follows the head. This catches a tag that is tied to the ring index or that fails to wrap, and a flush is checked to restart both counters.

// File: rtl/sqp_pkg.sv
package sqp_pkg;

  localparam int CID_W = 16;
  localparam int FID_W = 16;
  localparam logic [FID_W-1:0] FID_NONE = 16'hFFFF;

  typedef enum logic [7:0] {
    OPC_COPY      = 8'h00,
    OPC_RD_IMM    = 8'h01,
    OPC_WR_IMM    = 8'h02,
    OPC_RHOST_IRQ = 8'h06,
    OPC_NOP       = 8'h07
  } opc_e;

  localparam int CTL_BOTH_FID = 5;
  localparam int CTL_IRQ      = 6;
  localparam int CTL_FENCE    = 7;

  // Listed from most significant to least significant field.
  typedef struct packed {
    logic [FID_W-1:0] sfid;
    logic [FID_W-1:0] dfid;
    logic [31:0]      dst_hi;
    logic [31:0]      dst_lo;
    logic [31:0]      src_hi;
    logic [31:0]      src_lo;
    logic [31:0]      nbytes;
    logic [CID_W-1:0] cid;
    logic [15:0]      rsvd;
    logic [15:0]      tlp;
    logic [7:0]       ctl;
    opc_e             opc;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

endpackage

// File: rtl/sqp_ptrs.sv
module sqp_ptrs
  import sqp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  input  logic             len_ok,
  input  logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head,
  output logic [CID_W-1:0] cid,
  output logic             ring_full,
  output logic             accept
);

  logic [IDX_W-1:0] head_q, head_d, head_inc;
  logic [CID_W-1:0] cid_q, cid_d;
  logic             upd_en;

  always_comb begin
    head_inc  = head_q + IDX_W'(1);
    ring_full = (head_inc == tail);
    accept    = req_valid && !flush && len_ok && !ring_full;
    upd_en    = accept || flush;
    if (flush) begin
      head_d = '0;
      cid_d  = '0;
    end else begin
      head_d = head_inc;
      cid_d  = cid_q + CID_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cid_q  <= '0;
    end else if (upd_en) begin
      head_q <= head_d;
      cid_q  <= cid_d;
    end
  end

  assign head = head_q;
  assign cid  = cid_q;

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> head_q == $past(head_q) + IDX_W'(1)); // R8
  AST_CID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cid_q == $past(cid_q) + CID_W'(1)); // R7
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flush && (head_q + IDX_W'(1) == tail)) |=> $stable(head_q)); // R2
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (head_q == '0) && (cid_q == '0)); // R10

endmodule

// File: rtl/sqp_desc_build.sv
module sqp_desc_build
  import sqp_pkg::*;
(
  input  logic [63:0]      src,
  input  logic [63:0]      dst,
  input  logic [FID_W-1:0] sfid,
  input  logic [FID_W-1:0] dfid,
  input  logic [31:0]      nbytes,
  input  logic             want_irq,
  input  logic             want_fence,
  input  logic [CID_W-1:0] cid,
  output desc_t            desc
);

  logic [7:0] ctl;

  always_comb begin
    ctl               = '0;
    ctl[CTL_BOTH_FID] = (sfid != FID_NONE) && (dfid != FID_NONE);
    ctl[CTL_IRQ]      = want_irq;
    ctl[CTL_FENCE]    = want_fence;

    desc.opc    = OPC_COPY;
    desc.ctl    = ctl;
    desc.tlp    = '0;
    desc.rsvd   = '0;
    desc.cid    = cid;
    desc.nbytes = nbytes;
    desc.src_lo = src[31:0];
    desc.src_hi = src[63:32];
    desc.dst_lo = dst[31:0];
    desc.dst_hi = dst[63:32];
    desc.dfid   = dfid;
    desc.sfid   = sfid;
  end

endmodule

// File: rtl/sqp_ring_mem.sv
module sqp_ring_mem
  import sqp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  desc_t            wdesc,
  input  logic [LEN_W-1:0] wlen,
  input  logic [IDX_W-1:0] ridx,
  output desc_t            rdesc,
  output logic [LEN_W-1:0] rlen
);

  desc_t            slot_desc [DEPTH];
  logic [LEN_W-1:0] slot_len  [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (widx == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_desc[s] <= wdesc;
        slot_len[s]  <= wlen;
      end
    end
  end

  assign rdesc = slot_desc[ridx];
  assign rlen  = slot_len[ridx];

endmodule

// File: rtl/sq_producer.sv
module sq_producer
  import sqp_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter logic [31:0] MAX_LEN = 32'h0010_0000,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [63:0]       req_src,
  input  logic [63:0]       req_dst,
  input  logic [15:0]       req_sfid,
  input  logic [15:0]       req_dfid,
  input  logic [31:0]       req_len,
  input  logic              req_irq,
  input  logic              req_fence,
  input  logic [IDX_W-1:0]  cons_tail,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic              resp_full,
  output logic              resp_toolong,
  output logic [15:0]       resp_cid,
  output logic              db_valid,
  output logic [IDX_W-1:0]  db_head,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [255:0]      rd_desc,
  output logic [31:0]       rd_len
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic             len_ok, ring_full, accept;
  logic [IDX_W-1:0] head;
  logic [CID_W-1:0] cid;
  desc_t            new_desc, rd_d;

  assign len_ok = (req_len <= MAX_LEN);

  sqp_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_s), .flush(flush), .req_valid(req_valid),
    .len_ok(len_ok), .tail(cons_tail), .head(head), .cid(cid),
    .ring_full(ring_full), .accept(accept)
  );

  sqp_desc_build u_build (
    .src(req_src), .dst(req_dst), .sfid(req_sfid), .dfid(req_dfid),
    .nbytes(req_len), .want_irq(req_irq), .want_fence(req_fence),
    .cid(cid), .desc(new_desc)
  );

  sqp_ring_mem #(.DEPTH(DEPTH), .LEN_W(32)) u_mem (
    .clk(clk), .we(accept), .widx(head), .wdesc(new_desc), .wlen(req_len),
    .ridx(rd_idx), .rdesc(rd_d), .rlen(rd_len)
  );

  assign rd_desc = rd_d;

  // Response and doorbell: next-state then registers.
  logic             rv_d, rok_d, rfull_d, rlong_d, dbv_d;
  logic [CID_W-1:0] rcid_d;
  logic             rv_q, rok_q, rfull_q, rlong_q, dbv_q;
  logic [CID_W-1:0] rcid_q;
  logic [IDX_W-1:0] dbh_q;
  logic             dbh_en;

  always_comb begin
    rv_d    = req_valid && !flush;
    rok_d   = accept;
    rfull_d = rv_d && ring_full;
    rlong_d = rv_d && !len_ok;
    rcid_d  = cid;
    dbv_d   = rv_q && rok_q && !flush;
    dbh_en  = dbv_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rv_q    <= 1'b0;
      rok_q   <= 1'b0;
      rfull_q <= 1'b0;
      rlong_q <= 1'b0;
      rcid_q  <= '0;
      dbv_q   <= 1'b0;
      dbh_q   <= '0;
    end else begin
      rv_q    <= rv_d;
      rok_q   <= rok_d;
      rfull_q <= rfull_d;
      rlong_q <= rlong_d;
      dbv_q   <= dbv_d;
      if (rv_d) rcid_q <= rcid_d;
      if (dbh_en) dbh_q <= head;
    end
  end

  assign resp_valid   = rv_q;
  assign resp_ok      = rok_q;
  assign resp_full    = rfull_q;
  assign resp_toolong = rlong_q;
  assign resp_cid     = rcid_q;
  assign db_valid     = dbv_q;
  assign db_head      = dbh_q;

  AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && !flush && req_len > MAX_LEN) |=> (resp_valid && !resp_ok && resp_toolong)); // R3
  AST_DB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s)
    (resp_valid && resp_ok && !flush) |=> (db_valid && db_head == $past(head))); // R8
  AST_OK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_s)
    resp_ok |-> (resp_valid && !resp_full && !resp_toolong)); // R2
  AST_OPC_COPY: assert property (@(posedge clk) disable iff (!rst_s)
    accept |=> rd_idx != $past(head) || rd_d.opc == OPC_COPY); // R4

endmodule

// File: tb/sq_producer_test.sv
module sq_producer_test;
  import sqp_pkg::*;

  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [31:0] MAXL = 32'h0010_0000;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, req_valid = 1'b0;
  logic [63:0] req_src = '0, req_dst = '0;
  logic [15:0] req_sfid = 16'hFFFF, req_dfid = 16'hFFFF;
  logic [31:0] req_len = '0;
  logic req_irq = 1'b0, req_fence = 1'b0;
  logic [IDX_W-1:0] cons_tail = '0, rd_idx = '0;
  logic resp_valid, resp_ok, resp_full, resp_toolong, db_valid;
  logic [15:0] resp_cid;
  logic [IDX_W-1:0] db_head;
  logic [255:0] rd_desc;
  logic [31:0] rd_len;

  always #10 clk = ~clk;

  sq_producer #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_src(req_src), .req_dst(req_dst), .req_sfid(req_sfid),
    .req_dfid(req_dfid), .req_len(req_len), .req_irq(req_irq),
    .req_fence(req_fence), .cons_tail(cons_tail), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .resp_full(resp_full), .resp_toolong(resp_toolong),
    .resp_cid(resp_cid), .db_valid(db_valid), .db_head(db_head),
    .rd_idx(rd_idx), .rd_desc(rd_desc), .rd_len(rd_len)
  );

  int n_chk = 0, n_fail = 0;
  logic [18:0]      resp_q[$];   // {ok, full, toolong, cid}
  logic [IDX_W-1:0] db_q[$];
  desc_t            exp_desc [DEPTH];
  logic [31:0]      exp_len  [DEPTH];
  logic [IDX_W-1:0] m_head = '0;
  logic [15:0]      m_cid = '0;

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: call at a falling edge; returns at the next falling edge.
  task automatic send(input logic [63:0] s, input logic [63:0] d, input logic [15:0] sf,
                      input logic [15:0] df, input logic [31:0] len, input bit irq, input bit fen);
    bit full, lng, ok;
    desc_t e;
    req_valid = 1'b1; req_src = s; req_dst = d; req_sfid = sf; req_dfid = df;
    req_len = len; req_irq = irq; req_fence = fen;
    full = ((m_head + IDX_W'(1)) == cons_tail);
    lng  = (len > MAXL);
    ok   = !full && !lng;
    resp_q.push_back({ok, full, lng, m_cid});
    if (ok) begin
      e = '0;
      e.opc = OPC_COPY;
      e.ctl = {fen, irq, (sf != 16'hFFFF) && (df != 16'hFFFF), 5'b0};
      e.cid = m_cid; e.nbytes = len;
      e.src_lo = s[31:0]; e.src_hi = s[63:32];
      e.dst_lo = d[31:0]; e.dst_hi = d[63:32];
      e.dfid = df; e.sfid = sf;
      exp_desc[m_head] = e;
      exp_len[m_head]  = len;
      m_head = m_head + IDX_W'(1);
      m_cid  = m_cid + 16'd1;
      db_q.push_back(m_head);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_slot(input logic [IDX_W-1:0] i, input string req);
    rd_idx = i;
    #1;
    check(rd_desc == exp_desc[i], req, rd_desc, exp_desc[i]);
    check(rd_len == exp_len[i], "R9 side table length", rd_len, exp_len[i]);
  endtask

  // Monitor: compares responses and doorbells with the scoreboard queues.
  always @(negedge clk) begin
    logic [18:0] r;
    logic [IDX_W-1:0] h;
    if (rst_n) begin
      if (resp_valid) begin
        if (resp_q.size() == 0) check(1'b0, "R8 unexpected response", 1, 0);
        else begin
          r = resp_q.pop_front();
          check({resp_ok, resp_full, resp_toolong} == r[18:16], "R2/R3 response flags",
                {resp_ok, resp_full, resp_toolong}, r[18:16]);
          if (r[18]) check(resp_cid == r[15:0], "R7 command tag", resp_cid, r[15:0]);
        end
      end
      if (db_valid) begin
        if (db_q.size() == 0) check(1'b0, "R8 unexpected doorbell", 1, 0);
        else begin
          h = db_q.pop_front();
          check(db_head == h, "R8 doorbell head", db_head, h);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!resp_valid && !db_valid, "R1 idle after reset", {resp_valid, db_valid}, 0);

    // R4 R5 R6 descriptor contents and flags
    send(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 16'hFFFF, 16'hFFFF, 32'd64, 0, 0);
    send(64'hA, 64'hB, 16'h0003, 16'h0004, 32'd128, 1, 0);
    send(64'hC, 64'hD, 16'h0003, 16'hFFFF, 32'd8, 0, 1);
    send(64'hE, 64'hF, 16'hFFFF, 16'h0009, 32'd16, 1, 1);
    idle(3);
    check_slot(0, "R1 R4 first descriptor");
    check_slot(1, "R5 R6 both IDs valid with irq");
    check_slot(2, "R5 R6 source ID only with fence");
    check_slot(3, "R5 R6 destination ID only");

    // R3 length bound
    send(64'h100, 64'h200, 16'h1, 16'h2, MAXL, 0, 0);
    send(64'h100, 64'h200, 16'h1, 16'h2, MAXL + 32'd1, 0, 0);
    idle(3);
    check_slot(4, "R3 maximum length accepted");

    // R10 flush
    flush = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    m_head = '0; m_cid = '0;
    idle(2);

    // R2 fill the ring against tail 0
    cons_tail = '0;
    for (int i = 0; i < DEPTH; i++) send(64'(i), 64'(i + 100), 16'hFFFF, 16'hFFFF, 32'(i + 1), 0, 0);
    send(64'hBAD, 64'hBAD, 16'hFFFF, 16'hFFFF, MAXL + 32'd5, 0, 0);  // full and too long
    idle(3);
    check_slot(0, "R2 R10 slot 0 after flush");
    check_slot(14, "R2 last free slot");
    cons_tail = 4'd5;
    for (int i = 0; i < 5; i++) send(64'(i + 50), 64'(i + 60), 16'hFFFF, 16'hFFFF, 32'd32, 0, 0);
    send(64'h77, 64'h77, 16'hFFFF, 16'hFFFF, 32'd32, 0, 0);
    idle(3);
    check_slot(15, "R8 head wrap slot 15");
    check_slot(3, "R8 head wrap slot 3");
    check_slot(4, "R2 refused request left slot 4");

    // R7 command tag wrap: tail follows head so the ring stays empty
    for (int i = 0; i < 65540; i++) begin
      cons_tail = m_head;
      send(64'(i), 64'(i), 16'hFFFF, 16'hFFFF, 32'd4, 0, 0);
    end
    idle(4);
    check(resp_q.size() == 0 && db_q.size() == 0, "R7 R8 all results seen",
          resp_q.size() + db_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule